// File: doc/BRIEF.md
# Pulse Width Qualified Counter

This block counts pulses on two independent active-low inputs. It counts a pulse only when its low phase lasts at least a programmable number of clock cycles. The default minimum is 200 cycles, which is 2 us at a 100 MHz system clock. Each channel first resamples its raw input through a flop chain. A width timer then runs while the sampled input is low and is held at zero while it is high. The channel declares a pulse valid as soon as the timer reaches the minimum. It does not wait for the trailing edge, so a pulse of any length is counted once and the block never has to measure a full width.

After a channel accepts a pulse, it stays disarmed until it has seen its input high for at least one sampled cycle. This rule prevents a long pulse from being counted twice. It also bounds the event rate, because a new acceptance always needs a fresh low phase of full length. Each event count saturates at its largest value instead of wrapping. A per-channel overflow flag records that an event was lost at saturation. A synchronous clear resets the counts and flags of both channels.

Top module: `pwq_counter`

## Requirements
- R1: After reset every count is 0, every accept strobe and overflow flag is low, and the threshold register holds 200.
- R2: Each raw input passes through two flops before use. If a raw input falls just after clock edge 0 and stays low, accept_o for that channel is high in the cycle after edge T+2, where T is the threshold, and the count has risen by one after edge T+3.
- R3: A low phase that lasts fewer than T sampled cycles leaves the count, the accept strobe and the overflow flag unchanged.
- R4: A low phase of any length at or above T is counted exactly once. The channel re-arms only after at least one sampled cycle with the input high.
- R5: With the reset threshold, a low phase of 199 cycles is rejected and one of 200 cycles is counted.
- R6: A cycle with thr_wr_i high loads thr_val_i into the shared threshold register at the next edge. Thresholds of 0 and 1 both accept a pulse that is low for a single sampled cycle.
- R7: The channels are independent. A pulse on one channel never changes the count, strobe or flag of the other.
- R8: A count of width CNT_W (32 by default) stays at 2^CNT_W-1 when further pulses are accepted. Channel c occupies bits c*CNT_W upward of count_o.
- R9: The overflow flag of a channel is set when a pulse is accepted while its count is already at the maximum. The flag then stays set until a clear.
- R10: clr_i high at an edge zeroes both counts and both overflow flags. It takes precedence over an accept that arrives in the same cycle.
- R11: Each accept strobe is high for exactly one clock cycle per accepted pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pulse_n_i | input | NCH | Raw active-low pulse inputs, one per channel, asynchronous |
| clr_i | input | 1 | Synchronous clear of all counts and overflow flags |
| thr_wr_i | input | 1 | Load strobe for the width threshold |
| thr_val_i | input | THR_W | New threshold in clock cycles |
| accept_o | output | NCH | One-cycle strobe per channel when a pulse qualifies |
| count_o | output | NCH*CNT_W | Packed saturating event counts, channel 0 in the low bits |
| ovf_o | output | NCH | Sticky per-channel overflow flags |

## Verification
The latency from a falling raw input to the accept strobe is T+2 edges: two edges of synchronizer and T edges of timer. The count follows one edge after the strobe. A threshold write or a clear takes effect at the very next edge. The bench drives and samples on the falling clock edge and counts those edges from the moment it drives. It checks the strobe at exactly edge T+1 (expected low), edge T+2 (expected high) and edge T+3 (low again, with the count incremented). Rejected and long pulses are checked several cycles after release, beyond the last edge at which any result could change. The clear-priority test raises clr_i on the cycle in which the strobe is observed high.

// File: rtl/pwq_pkg.sv
`timescale 1ns/1ps
package pwq_pkg;

    // Arming state of one width qualifier
    typedef enum logic {
        QS_ARMED = 1'b0,   // waiting for a low phase to reach the threshold
        QS_SPENT = 1'b1    // pulse already accepted, wait for the input to go high
    } qual_state_e;

    // Number of channels the block is built for by default
    localparam int DEF_CHANNELS = 2;

endpackage

// File: rtl/pwq_sync.sv
`timescale 1ns/1ps
module pwq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[TOP];

endmodule

// File: rtl/pwq_width_qual.sv
`timescale 1ns/1ps
module pwq_width_qual
    import pwq_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             accept_o
);
    localparam int EXT_W = THR_W + 1;

    typedef struct packed {
        qual_state_e      state;
        logic [THR_W-1:0] timer;
        logic             accept;
    } qual_t;

    qual_t            qual_d, qual_q;
    logic [EXT_W-1:0] tmr_inc;
    logic [EXT_W-1:0] thr_eff;

    always_comb begin
        thr_eff = (thr_i == '0) ? EXT_W'(1) : {1'b0, thr_i};
        tmr_inc = {1'b0, qual_q.timer} + EXT_W'(1);
        qual_d        = qual_q;
        qual_d.accept = 1'b0;
        if (!active_i) begin
            qual_d.state = QS_ARMED;
            qual_d.timer = '0;
        end else if (qual_q.state == QS_ARMED) begin
            qual_d.timer = tmr_inc[THR_W-1:0];
            if (tmr_inc >= thr_eff) begin
                qual_d.accept = 1'b1;
                qual_d.state  = QS_SPENT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q.state  <= QS_ARMED;
            qual_q.timer  <= '0;
            qual_q.accept <= 1'b0;
        end else begin
            qual_q <= qual_d;
        end
    end

    assign accept_o = qual_q.accept;

    AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q.accept |=> !qual_q.accept); // R11

    AST_ACCEPT_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q.accept |-> $past(active_i)); // R2

    AST_NO_REACCEPT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_q.accept && active_i) |=> !qual_q.accept); // R4

    AST_SPENT_UNTIL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_q.state == QS_SPENT && active_i) |=> !qual_q.accept); // R4

endmodule

// File: rtl/pwq_event_count.sv
`timescale 1ns/1ps
module pwq_event_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } evc_t;

    evc_t evc_d, evc_q;
    logic at_max;

    always_comb begin
        at_max = (evc_q.cnt == CNT_MAX);
        evc_d  = evc_q;
        if (clr_i) begin
            evc_d.cnt = '0;
            evc_d.ovf = 1'b0;
        end else if (inc_i) begin
            if (at_max) evc_d.ovf = 1'b1;
            else        evc_d.cnt = evc_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evc_q.cnt <= '0;
            evc_q.ovf <= 1'b0;
        end else begin
            evc_q <= evc_d;
        end
    end

    assign count_o = evc_q.cnt;
    assign ovf_o   = evc_q.ovf;

    AST_COUNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (evc_q.cnt == CNT_MAX && !clr_i) |=> evc_q.cnt == CNT_MAX); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (evc_q.ovf && !clr_i) |=> evc_q.ovf); // R9

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evc_q.ovf) |-> ($past(inc_i) && $past(evc_q.cnt) == CNT_MAX)); // R9

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (evc_q.cnt == '0 && !evc_q.ovf)); // R10

    AST_NO_STEP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(evc_q.cnt)); // R3

endmodule

// File: rtl/pwq_counter.sv
`timescale 1ns/1ps
module pwq_counter
    import pwq_pkg::*;
#(
    parameter int NCH         = DEF_CHANNELS,
    parameter int CNT_W       = 32,
    parameter int THR_W       = 16,
    parameter int THR_RESET   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       pulse_n_i,
    input  logic                 clr_i,
    input  logic                 thr_wr_i,
    input  logic [THR_W-1:0]     thr_val_i,
    output logic [NCH-1:0]       accept_o,
    output logic [NCH*CNT_W-1:0] count_o,
    output logic [NCH-1:0]       ovf_o
);
    localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RESET);

    typedef struct packed {
        logic [THR_W-1:0] thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (thr_wr_i) cfg_d.thr = thr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q.thr <= THR_INIT;
        else        cfg_q     <= cfg_d;
    end

    AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i |=> cfg_q.thr == $past(thr_val_i)); // R6

    AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_wr_i |=> $stable(cfg_q.thr)); // R6

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic pin_sync;
        logic pin_active;
        logic chan_accept;

        pwq_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(pulse_n_i[ch]),
            .sync_o (pin_sync)
        );

        assign pin_active = ~pin_sync;

        pwq_width_qual #(
            .THR_W(THR_W)
        ) i_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .active_i(pin_active),
            .thr_i   (cfg_q.thr),
            .accept_o(chan_accept)
        );

        pwq_event_count #(
            .CNT_W(CNT_W)
        ) i_count (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr_i),
            .inc_i  (chan_accept),
            .count_o(count_o[ch*CNT_W +: CNT_W]),
            .ovf_o  (ovf_o[ch])
        );

        assign accept_o[ch] = chan_accept;
    end

endmodule

// File: tb/test_pwq_counter.sv
`timescale 1ns/1ps
module test_pwq_counter;
    localparam int NCH = 2;
    localparam int CW  = 4;
    localparam int TW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  pulse_n = '1;
    logic            clr = 1'b0;
    logic            thr_wr = 1'b0;
    logic [TW-1:0]   thr_val = '0;
    logic [NCH-1:0]  accept;
    logic [NCH*CW-1:0] count;
    logic [NCH-1:0]  ovf;

    int checks = 0;
    int errors = 0;
    int dbl_strobe = 0;
    logic [NCH-1:0] acc_prev = '0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwq_counter #(
        .NCH(NCH), .CNT_W(CW), .THR_W(TW), .THR_RESET(200), .SYNC_STAGES(2)
    ) i_pwq_counter (
        .clk(clk), .rst_n(rst_n), .pulse_n_i(pulse_n), .clr_i(clr),
        .thr_wr_i(thr_wr), .thr_val_i(thr_val),
        .accept_o(accept), .count_o(count), .ovf_o(ovf)
    );

    // strobe width monitor (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++)
                if (accept[c] && acc_prev[c]) dbl_strobe++;
            acc_prev <= accept;
        end
    end

    function automatic int cnt(input int ch);
        return int'(count[ch*CW +: CW]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_thr(input int v);
        @(negedge clk);
        thr_wr = 1'b1; thr_val = TW'(v);
        @(negedge clk);
        thr_wr = 1'b0;
        idle(2);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // drive channel ch low for len cycles, then high
    task automatic pulse(input int ch, input int len);
        @(negedge clk);
        pulse_n[ch] = 1'b0;
        idle(len);
        pulse_n[ch] = 1'b1;
    endtask

    task automatic t_reset();
        chk(cnt(0) == 0 && cnt(1) == 0, "R1 counts", cnt(0) + cnt(1), 0);
        chk(accept == '0 && ovf == '0, "R1 strobes/flags", int'({accept, ovf}), 0);
    endtask

    task automatic t_default_thr();
        int c0;
        c0 = cnt(0);
        pulse(0, 199); idle(8);
        chk(cnt(0) == c0, "R5 199-cycle pulse rejected (R3)", cnt(0), c0);
        pulse(0, 200); idle(8);
        chk(cnt(0) == c0 + 1, "R5 200-cycle pulse counted (R1 reset threshold)", cnt(0), c0 + 1);
    endtask

    task automatic t_timing();
        int c0;
        set_thr(5);
        c0 = cnt(0);
        @(negedge clk);
        pulse_n[0] = 1'b0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (i == 6) chk(accept[0] == 1'b0, "R2 strobe not before T+2", int'(accept[0]), 0);
            if (i == 7) begin
                chk(accept[0] == 1'b1, "R2 strobe at T+2", int'(accept[0]), 1);
                chk(cnt(0) == c0, "R2 count not yet updated", cnt(0), c0);
            end
            if (i == 8) begin
                chk(accept[0] == 1'b0, "R11 strobe one cycle", int'(accept[0]), 0);
                chk(cnt(0) == c0 + 1, "R2 count at T+3", cnt(0), c0 + 1);
            end
        end
        pulse_n[0] = 1'b1;
        idle(4);
    endtask

    task automatic t_short();
        int c1;
        c1 = cnt(1);
        pulse(1, 4); idle(8);
        chk(cnt(1) == c1 && ovf[1] == 1'b0, "R3 short pulse ignored", cnt(1), c1);
    endtask

    task automatic t_long();
        int c0;
        c0 = cnt(0);
        pulse(0, 60); idle(6);
        chk(cnt(0) == c0 + 1, "R4 long pulse counted once", cnt(0), c0 + 1);
        pulse(0, 20); pulse(0, 20); idle(6);
        chk(cnt(0) == c0 + 3, "R4 one high cycle re-arms", cnt(0), c0 + 3);
    endtask

    task automatic t_thr_small();
        int c0;
        set_thr(0);
        c0 = cnt(0);
        pulse(0, 1); idle(6);
        chk(cnt(0) == c0 + 1, "R6 threshold 0 accepts 1 cycle", cnt(0), c0 + 1);
        set_thr(1);
        pulse(0, 1); idle(6);
        chk(cnt(0) == c0 + 2, "R6 threshold 1 accepts 1 cycle", cnt(0), c0 + 2);
        set_thr(5);
    endtask

    task automatic t_indep();
        int c0, c1;
        do_clear(); idle(1);
        c0 = cnt(0); c1 = cnt(1);
        @(negedge clk);
        pulse_n = 2'b00;
        idle(3);
        pulse_n[1] = 1'b1;
        idle(7);
        pulse_n[0] = 1'b1;
        idle(6);
        chk(cnt(0) == c0 + 1, "R7 ch0 counted", cnt(0), c0 + 1);
        chk(cnt(1) == c1, "R7 ch1 unaffected", cnt(1), c1);
    endtask

    task automatic t_saturate();
        do_clear(); idle(1);
        for (int k = 0; k < 15; k++) begin
            pulse(1, 6); idle(3);
        end
        idle(4);
        chk(cnt(1) == 15 && ovf[1] == 1'b0, "R8 reach max without flag", cnt(1), 15);
        pulse(1, 6); idle(6);
        chk(cnt(1) == 15, "R8 saturates", cnt(1), 15);
        chk(ovf[1] == 1'b1, "R9 overflow set", int'(ovf[1]), 1);
        chk(ovf[0] == 1'b0 && cnt(0) == 0, "R7 other channel flag clear", int'(ovf[0]), 0);
        idle(10);
        chk(ovf[1] == 1'b1, "R9 overflow sticky", int'(ovf[1]), 1);
        do_clear(); idle(1);
        chk(cnt(1) == 0 && ovf == '0, "R10 clear zeroes count and flag", cnt(1) + int'(ovf), 0);
    endtask

    task automatic t_clr_priority();
        bit seen;
        seen = 1'b0;
        do_clear(); idle(1);
        @(negedge clk);
        pulse_n[1] = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (accept[1]) begin
                seen = 1'b1;
                clr = 1'b1;
            end
        end
        @(negedge clk);
        clr = 1'b0;
        pulse_n[1] = 1'b1;
        idle(4);
        chk(seen, "R10 strobe observed", int'(seen), 1);
        chk(cnt(1) == 0, "R10 clear beats accept", cnt(1), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_thr();
        t_timing();
        t_short();
        t_long();
        t_thr_small();
        t_indep();
        t_saturate();
        t_clr_priority();
        chk(dbl_strobe == 0, "R11 no multi-cycle strobe", dbl_strobe, 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule